// File: doc/BRIEF.md
# Compact 8-bit Single-Cycle Core with 16-bit Instructions

This block is a small single-cycle processor datapath. It has eight 8-bit registers, a decoder for a compact 16-bit instruction format, an ALU and a comparator. It has no program counter and no memories. An external agent presents one 16-bit instruction on the two input bytes. On each rising clock edge the core executes that instruction, updates at most one register and registers an 8-bit result.

Arithmetic, shift and load-immediate instructions change the register file and drive a zero result. A store drives the value of one register onto the result bus. A branch evaluates its condition and reports it as 1 or 0 on the result bus. Nothing else happens for either of them. This lets a tester step through a program by hand and observe the state through stores and branches.

Top module: `tiny8_core`

## Requirements
- R1: The instruction is {instr_hi, instr_lo}, and bits [1:0] are the opcode. With opcode 00, the register-register forms use funct3=[15:13], funct2=[12:11], rs2=[10:8], rs1=[7:5] and rd=[4:2]. The operations are AND (000/00), OR (001/00), ADD (010/00), SUB (011/00, rs1-rs2) and XOR (001/01). Arithmetic wraps modulo 256.
- R2: SLT (funct3=111, funct2=00, opcode 00) writes 1 into rd when rs1 < rs2 as signed 8-bit values, and 0 otherwise.
- R3: With opcode 01, the shift amount is the unsigned imm5=[12:8]. The shifts are SLL (funct3=100), SRL (101) and SRA (110). For an amount of 8 or more, SLL and SRL give 0 and SRA gives eight copies of the sign bit.
- R4: ADDI (funct3=010, opcode 01) writes rs1+imm5 into rd, and SUBI (011) writes rs1-imm5. The immediate is zero-extended and the result wraps modulo 256.
- R5: A load (opcode 10, bits [7:5]=000) writes the byte [15:8] into rd=[4:2].
- R6: A store has opcode 11, bits [15:8]=0 and bits [4:2]=0. It drives the value of rs1=[7:5] onto result and writes no register.
- R7: Branches have opcode 11 and bits [4:2]=0. BEQ (funct3=011, funct2=00) sets result to 1 when rs1==rs2. BNE (011/10) sets it to 1 when rs1!=rs2. BLT (111/00) sets it to 1 when rs1<rs2 as signed values. Otherwise result is 0, and no register is written.
- R8: Every valid opcode 00, 01 and 10 instruction drives result to 0.
- R9: Any encoding not listed above writes no register and drives result to 0.
- R10: While rst_n is low at a rising edge, all eight registers and result clear to 0.
- R11: Result and register writes take effect on the rising edge that executes the instruction. The next instruction reads the new register value. Register 0 is an ordinary register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock; one instruction per edge |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_lo | input | 8 | Instruction bits [7:0] |
| instr_hi | input | 8 | Instruction bits [15:8] |
| result | output | 8 | Registered result byte |

## Verification
The bench loads an operand pair of 5 and -13, so signed and unsigned orderings disagree. A core that compared without sign on SLT or BLT would return the wrong bit.

Shifts by exactly 8, by 9 and by 12 are tested. A core that used only the low three bits of the amount would return a rotated or partly shifted value instead of 0 or sign fill.

Near-miss encodings are executed against a register that holds a known value. These are a branch or store with nonzero bits [4:2], a load with nonzero bits [7:5], and unused function codes. A loose decoder would corrupt that register or drive a nonzero result.

Back-to-back dependent instructions and a reset in the middle of a run are also covered. They expose a stale read and an incomplete clear.

// File: rtl/tiny8_core.sv
module tiny8_core (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] instr_lo,
  input  logic [7:0] instr_hi,
  output logic [7:0] result
);
  localparam logic [1:0] OP_RR = 2'b00, OP_RI = 2'b01, OP_LD = 2'b10, OP_SB = 2'b11;

  logic [7:0][7:0] rf;

  wire [15:0] ins  = {instr_hi, instr_lo};
  wire [1:0]  op   = ins[1:0];
  wire [2:0]  f3   = ins[15:13];
  wire [1:0]  f2   = ins[12:11];
  wire [2:0]  rs2a = ins[10:8];
  wire [2:0]  rs1a = ins[7:5];
  wire [2:0]  rda  = ins[4:2];
  wire [4:0]  imm5 = ins[12:8];
  wire [7:0]  imm8 = ins[15:8];

  wire [7:0] a = rf[rs1a];
  wire [7:0] b = rf[rs2a];

  wire       big   = imm5 >= 5'd8;
  wire [7:0] sll_v = big ? 8'h00 : a << imm5[2:0];
  wire [7:0] srl_v = big ? 8'h00 : a >> imm5[2:0];
  wire [7:0] sra_v = big ? {8{a[7]}} : 8'($signed(a) >>> imm5[2:0]);
  wire       lt    = $signed(a) < $signed(b);

  wire is_load   = (op == OP_LD) && (rs1a == 3'b000);
  wire is_store  = (op == OP_SB) && (ins[15:8] == 8'h00) && (rda == 3'b000);
  wire is_branch = (op == OP_SB) && (rda == 3'b000) &&
                   ((f3 == 3'b011 && f2 == 2'b00) || (f3 == 3'b011 && f2 == 2'b10) ||
                    (f3 == 3'b111 && f2 == 2'b00));

  logic       wen;
  logic [7:0] wdata;
  logic [7:0] rnext;

  always_comb begin
    wen   = 1'b0;
    wdata = 8'h00;
    rnext = 8'h00;
    unique case (op)
      OP_RR: begin
        wen = 1'b1;
        case ({f3, f2})
          5'b000_00: wdata = a & b;
          5'b001_00: wdata = a | b;
          5'b010_00: wdata = a + b;
          5'b011_00: wdata = a - b;
          5'b001_01: wdata = a ^ b;
          5'b111_00: wdata = {7'd0, lt};
          default:   wen = 1'b0;
        endcase
      end
      OP_RI: begin
        wen = 1'b1;
        case (f3)
          3'b100:  wdata = sll_v;
          3'b101:  wdata = srl_v;
          3'b110:  wdata = sra_v;
          3'b010:  wdata = a + {3'd0, imm5};
          3'b011:  wdata = a - {3'd0, imm5};
          default: wen = 1'b0;
        endcase
      end
      OP_LD: begin
        wen   = is_load;
        wdata = imm8;
      end
      OP_SB: begin
        if (is_store)
          rnext = a;
        else if (is_branch) begin
          if (f3 == 3'b111)     rnext = {7'd0, lt};
          else if (f2 == 2'b10) rnext = {7'd0, a != b};
          else                  rnext = {7'd0, a == b};
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rf     <= '0;
      result <= 8'h00;
    end else begin
      if (wen) rf[rda] <= wdata;
      result <= rnext;
    end
  end

  // R8
  quiet_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op != OP_SB) |=> (result == 8'h00));

  // R6
  store_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_store |=> (result == $past(a)));

  // R7
  branch_bool_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_branch |=> (result[7:1] == 7'd0));

  // R6 R7
  sb_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SB) |=> $stable(rf));

  // R9
  bad_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_LD && !is_load) |=> ($stable(rf) && result == 8'h00));

  // R9
  bad_sb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SB && !is_store && !is_branch) |=> (result == 8'h00));

  // R5
  load_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_load |=> (rf[$past(rda)] == $past(imm8)));
endmodule

// File: tb/sim_tiny8_core.sv
module sim_tiny8_core;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] instr_lo = 8'h00;
  logic [7:0] instr_hi = 8'h00;
  logic [7:0] result;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  tiny8_core u0 (.clk(clk), .rst_n(rst_n), .instr_lo(instr_lo), .instr_hi(instr_hi), .result(result));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] rr(input logic [2:0] f3, input logic [1:0] f2,
                                     input logic [2:0] s2, input logic [2:0] s1, input logic [2:0] d);
    return {f3, f2, s2, s1, d, 2'b00};
  endfunction
  function automatic logic [15:0] ri(input logic [2:0] f3, input logic [4:0] im,
                                     input logic [2:0] s1, input logic [2:0] d);
    return {f3, im, s1, d, 2'b01};
  endfunction
  function automatic logic [15:0] ld(input logic [7:0] im, input logic [2:0] d);
    return {im, 3'b000, d, 2'b10};
  endfunction
  function automatic logic [15:0] st(input logic [2:0] s1);
    return {8'h00, s1, 3'b000, 2'b11};
  endfunction
  function automatic logic [15:0] br(input logic [2:0] f3, input logic [1:0] f2,
                                     input logic [2:0] s2, input logic [2:0] s1);
    return {f3, f2, s2, s1, 3'b000, 2'b11};
  endfunction

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic exec(input logic [15:0] ins);
    @(negedge clk);
    {instr_hi, instr_lo} = ins;
    @(posedge clk);
    #1;
  endtask

  task automatic expect_reg(input string req, input logic [2:0] r, input logic [7:0] exp);
    exec(st(r));
    chk(req, result, exp);
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    #1;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset;
    do_reset();
    chk("R10 result", result, 8'h00);
    for (int r = 0; r < 8; r++) expect_reg("R10 reg", 3'(r), 8'h00);
  endtask

  task automatic t_load;
    exec(ld(8'h05, 3'd1)); chk("R8 load result", result, 8'h00);
    exec(ld(8'hF3, 3'd2));
    exec(ld(8'h5A, 3'd0));
    expect_reg("R5 r1", 3'd1, 8'h05);
    expect_reg("R5 r2", 3'd2, 8'hF3);
    expect_reg("R11 r0 ordinary", 3'd0, 8'h5A);
  endtask

  task automatic t_rr;
    exec(rr(3'b000, 2'b00, 3'd2, 3'd1, 3'd3)); chk("R8 rr result", result, 8'h00);
    expect_reg("R1 AND", 3'd3, 8'h01);
    exec(rr(3'b001, 2'b00, 3'd2, 3'd1, 3'd3)); expect_reg("R1 OR", 3'd3, 8'hF7);
    exec(rr(3'b010, 2'b00, 3'd2, 3'd1, 3'd3)); expect_reg("R1 ADD", 3'd3, 8'hF8);
    exec(rr(3'b011, 2'b00, 3'd2, 3'd1, 3'd3)); expect_reg("R1 SUB", 3'd3, 8'h12);
    exec(rr(3'b001, 2'b01, 3'd2, 3'd1, 3'd3)); expect_reg("R1 XOR", 3'd3, 8'hF6);
    exec(rr(3'b111, 2'b00, 3'd2, 3'd1, 3'd4)); expect_reg("R2 SLT 5<-13", 3'd4, 8'h00);
    exec(rr(3'b111, 2'b00, 3'd1, 3'd2, 3'd4)); expect_reg("R2 SLT -13<5", 3'd4, 8'h01);
  endtask

  task automatic t_ri;
    exec(ri(3'b100, 5'd3, 3'd2, 3'd5)); chk("R8 ri result", result, 8'h00);
    expect_reg("R3 SLL 3", 3'd5, 8'h98);
    exec(ri(3'b100, 5'd8, 3'd2, 3'd5)); expect_reg("R3 SLL 8", 3'd5, 8'h00);
    exec(ri(3'b101, 5'd4, 3'd2, 3'd5)); expect_reg("R3 SRL 4", 3'd5, 8'h0F);
    exec(ri(3'b101, 5'd9, 3'd2, 3'd5)); expect_reg("R3 SRL 9", 3'd5, 8'h00);
    exec(ri(3'b110, 5'd2, 3'd2, 3'd5)); expect_reg("R3 SRA 2", 3'd5, 8'hFC);
    exec(ri(3'b110, 5'd12, 3'd2, 3'd5)); expect_reg("R3 SRA 12", 3'd5, 8'hFF);
    exec(ri(3'b110, 5'd1, 3'd1, 3'd5)); expect_reg("R3 SRA pos", 3'd5, 8'h02);
    exec(ri(3'b010, 5'd31, 3'd2, 3'd6)); expect_reg("R4 ADDI wrap", 3'd6, 8'h12);
    exec(ri(3'b011, 5'd6, 3'd1, 3'd6)); expect_reg("R4 SUBI wrap", 3'd6, 8'hFF);
  endtask

  task automatic t_branch;
    exec(br(3'b011, 2'b00, 3'd1, 3'd1)); chk("R7 BEQ eq", result, 8'h01);
    exec(br(3'b011, 2'b00, 3'd2, 3'd1)); chk("R7 BEQ ne", result, 8'h00);
    exec(br(3'b011, 2'b10, 3'd2, 3'd1)); chk("R7 BNE ne", result, 8'h01);
    exec(br(3'b011, 2'b10, 3'd1, 3'd1)); chk("R7 BNE eq", result, 8'h00);
    exec(br(3'b111, 2'b00, 3'd1, 3'd2)); chk("R7 BLT -13<5", result, 8'h01);
    exec(br(3'b111, 2'b00, 3'd2, 3'd1)); chk("R7 BLT 5<-13", result, 8'h00);
    expect_reg("R7 no write r1", 3'd1, 8'h05);
  endtask

  task automatic t_illegal;
    exec(ld(8'h44, 3'd7));
    exec(rr(3'b100, 2'b00, 3'd1, 3'd1, 3'd7)); chk("R9 rr unused result", result, 8'h00);
    expect_reg("R9 rr unused", 3'd7, 8'h44);
    exec(ri(3'b000, 5'd1, 3'd1, 3'd7)); expect_reg("R9 ri unused", 3'd7, 8'h44);
    exec({8'h11, 3'b001, 3'd7, 2'b10}); chk("R9 bad load result", result, 8'h00);
    expect_reg("R9 bad load", 3'd7, 8'h44);
    exec({3'b011, 2'b00, 3'd1, 3'd1, 3'b001, 2'b11}); chk("R9 branch rd!=0", result, 8'h00);
    exec({8'h00, 3'd7, 3'b010, 2'b11}); chk("R9 store rd!=0", result, 8'h00);
    exec({3'b000, 2'b01, 3'd0, 3'd7, 3'b000, 2'b11}); chk("R9 sb unused", result, 8'h00);
    expect_reg("R6 store r7", 3'd7, 8'h44);
  endtask

  task automatic t_chain;
    exec(ld(8'h80, 3'd3));
    exec(ri(3'b010, 5'd1, 3'd3, 3'd3));
    exec(rr(3'b010, 2'b00, 3'd3, 3'd3, 3'd3));
    expect_reg("R11 chain", 3'd3, 8'h02);
    do_reset();
    expect_reg("R10 mid reset r3", 3'd3, 8'h00);
    expect_reg("R10 mid reset r7", 3'd7, 8'h00);
  endtask

  initial begin
    t_reset();
    t_load();
    t_rr();
    t_ri();
    t_branch();
    t_illegal();
    t_chain();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule